// File: doc/BRIEF.md
# Per-Channel Short-Fault Protection Controller

This block sits between the latched output commands of a serially controlled eight-way low-side switch and the gate drives of its power stages. On every clock it decides which channels may conduct. It weighs each channel's commanded state against that channel's short-circuit and over-temperature sense flags and against a single overvoltage flag that applies to all channels. It also returns a per-channel fault word, which status readback shifts out.

A mode input picks how a short is handled. In latch mode the affected channel is switched off and held off. Every other channel keeps running. In limit mode the channel keeps conducting in current limit. It stops only when the short clears or the channel overheats. A latched short is not cleared by a dedicated command. Instead, every completed serial write, seen as the rising edge of the active-low chip select, clears all short latches so that each tripped channel is tried again.

Top module: `chan_guard`

## Requirements
- R1: With `limit_mode_i` low, a short sensed on a channel commanded on (`cmd_on_i` bit = 1 means on) sets that channel's latch. The channel's `gate_en_o` bit goes low after the next clock edge and stays low. The other channels are unaffected. A latched channel shows 1 in `fault_o`.
- R2: With `limit_mode_i` high, a short does not latch. A channel that is otherwise allowed keeps `gate_en_o` high, and its `limit_o` and `fault_o` bits are 1 while the short is sensed. A channel that is blocked by over-temperature or overvoltage shows 0 in `limit_o`.
- R3: A rising edge on `cs_n_i` clears every short latch at that clock edge. A tripped channel is re-enabled for that cycle. If the short is still present, the channel latches again at the following edge.
- R4: A channel's over-temperature flag forces only that channel's `gate_en_o` low and sets its `fault_o` bit. When the flag drops, the channel follows its command again without any write.
- R5: `ovolt_i` high forces every `gate_en_o` bit low and every `fault_o` bit high.
- R6: An open-load flag sets a channel's `fault_o` bit only while that channel is commanded off.
- R7: `rst_ni` low drives `gate_en_o`, `fault_o` and `limit_o` to zero at once and clears every short latch.
- R8: A short sensed on a channel commanded off leaves no latch and no fault.
- R9: A latched short remains latched when `limit_mode_i` is switched high. Only the write retry of R3 clears it.
- R10: All outputs are registered. They reflect the inputs present at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_on_i | input | NUM_CH | Commanded state per channel, 1 = on |
| short_i | input | NUM_CH | Short/overcurrent sense per channel |
| hot_i | input | NUM_CH | Over-temperature sense per channel |
| open_i | input | NUM_CH | Open-load sense per channel |
| ovolt_i | input | 1 | Global overvoltage flag |
| limit_mode_i | input | 1 | 1 = run shorts in current limit, 0 = latch off |
| cs_n_i | input | 1 | Active-low serial chip select; rising edge retries shorts |
| gate_en_o | output | NUM_CH | Gate enable per channel |
| limit_o | output | NUM_CH | Channel conducting in current limit |
| fault_o | output | NUM_CH | Per-channel fault indication for readback |

## Verification
Every output is one register stage from the inputs. A stimulus applied before clock edge k is therefore visible just after edge k, and the retry pulse takes effect at the same edge as the chip-select rise with the default zero synchronizer stages. The bench drives each vector on a falling edge. It compares outputs on the next falling edge, before it drives the following vector, so each check lands exactly one edge after its cause. The re-latch after a retry is checked at the next vector one edge later. Reset is checked a fraction of a nanosecond after `rst_ni` falls, without waiting for a clock.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;
  localparam int unsigned DEF_NUM_CH = 8;

  typedef struct packed {
    logic shrt;
    logic hot;
    logic open;
  } ch_sense_t;

  typedef struct packed {
    logic gate;
    logic lim;
    logic fault;
  } ch_out_t;
endpackage

// File: rtl/chan_guard_retry.sv
module chan_guard_retry #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic retry_o
);
  logic cs_s;
  logic cs_prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign cs_s = cs_n_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], cs_n_i};
      end
      assign cs_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // idle-high reset: no spurious retry after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_prev_q <= 1'b1;
    else         cs_prev_q <= cs_s;
  end

  assign retry_o = cs_s & ~cs_prev_q;
endmodule

// File: rtl/chan_guard_lane.sv
module chan_guard_lane
  import chan_guard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_on_i,
  input  ch_sense_t sense_i,
  input  logic      ovolt_i,
  input  logic      limit_mode_i,
  input  logic      retry_i,
  output ch_out_t   out_o
);
  logic lat_q, lat_d;
  logic trip;
  logic run_d, lim_d, fault_d;
  ch_out_t out_q;

  assign trip  = sense_i.shrt & cmd_on_i & ~limit_mode_i;
  // retry wins: channel gets one cycle to prove the short is gone
  assign lat_d = retry_i ? 1'b0 : (lat_q | trip);

  assign run_d   = cmd_on_i & ~sense_i.hot & ~ovolt_i & ~lat_d;
  assign lim_d   = run_d & sense_i.shrt & limit_mode_i;
  assign fault_d = lat_d | sense_i.hot | ovolt_i | lim_d | (sense_i.open & ~cmd_on_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      out_q <= '0;
    end else begin
      lat_q       <= lat_d;
      out_q.gate  <= run_d;
      out_q.lim   <= lim_d;
      out_q.fault <= fault_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/chan_guard.sv
module chan_guard
  import chan_guard_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cmd_on_i,
  input  logic [NUM_CH-1:0] short_i,
  input  logic [NUM_CH-1:0] hot_i,
  input  logic [NUM_CH-1:0] open_i,
  input  logic              ovolt_i,
  input  logic              limit_mode_i,
  input  logic              cs_n_i,
  output logic [NUM_CH-1:0] gate_en_o,
  output logic [NUM_CH-1:0] limit_o,
  output logic [NUM_CH-1:0] fault_o
);
  logic retry;

  chan_guard_retry #(.SYNC_STAGES(SYNC_STAGES)) u_retry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (cs_n_i),
    .retry_o (retry)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    ch_sense_t sense;
    ch_out_t   res;

    assign sense = '{shrt: short_i[c], hot: hot_i[c], open: open_i[c]};

    chan_guard_lane u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cmd_on_i     (cmd_on_i[c]),
      .sense_i      (sense),
      .ovolt_i      (ovolt_i),
      .limit_mode_i (limit_mode_i),
      .retry_i      (retry),
      .out_o        (res)
    );

    assign gate_en_o[c] = res.gate;
    assign limit_o[c]   = res.lim;
    assign fault_o[c]   = res.fault;
  end
endmodule

// File: rtl/chan_guard_chk.sv
module chan_guard_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] cmd_on_i,
  input logic [NUM_CH-1:0] short_i,
  input logic [NUM_CH-1:0] hot_i,
  input logic              ovolt_i,
  input logic              limit_mode_i,
  input logic              cs_n_i,
  input logic [NUM_CH-1:0] gate_en_o,
  input logic [NUM_CH-1:0] limit_o,
  input logic [NUM_CH-1:0] fault_o
);
  p_short_latch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!limit_mode_i && !(cs_n_i && !$past(cs_n_i))) |=> ((gate_en_o & $past(short_i)) == '0));

  p_no_limit_latchmode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !limit_mode_i |=> (limit_o == '0));

  p_hot_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((gate_en_o & $past(hot_i)) == '0));

  p_ovolt_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovolt_i |=> (gate_en_o == '0 && fault_o == '1));

  p_reset_clear_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (gate_en_o == '0 && limit_o == '0 && fault_o == '0));

  p_gate_needs_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((gate_en_o & ~$past(cmd_on_i)) == '0));
endmodule

bind chan_guard chan_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_on_i     (cmd_on_i),
  .short_i      (short_i),
  .hot_i        (hot_i),
  .ovolt_i      (ovolt_i),
  .limit_mode_i (limit_mode_i),
  .cs_n_i       (cs_n_i),
  .gate_en_o    (gate_en_o),
  .limit_o      (limit_o),
  .fault_o      (fault_o)
);

// File: tb/chan_guard_bench.sv
`timescale 1ns/1ps
module chan_guard_bench;
  localparam int N = 8;
  localparam real CLK_NS = 4.0;
  localparam int ROWS = 27;

  // {cmd, short, hot, open, ovolt, mode, cs_n, exp_gate, exp_fault, exp_lim}
  localparam logic [58:0] TBL [ROWS] = '{
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFF,8'h00,8'h00},
    {8'hFF,8'h04,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFB,8'h04,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFB,8'h04,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b0, 8'hFB,8'h04,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFF,8'h00,8'h00},
    {8'hFF,8'h04,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFB,8'h04,8'h00},
    {8'hFF,8'h04,8'h00,8'h00,1'b0,1'b0,1'b0, 8'hFB,8'h04,8'h00},
    {8'hFF,8'h04,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFF,8'h00,8'h00},
    {8'hFF,8'h04,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFB,8'h04,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b0, 8'hFB,8'h04,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFF,8'h00,8'h00},
    {8'hFF,8'h81,8'h00,8'h00,1'b0,1'b1,1'b1, 8'hFF,8'h81,8'h81},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b1,1'b1, 8'hFF,8'h00,8'h00},
    {8'hFF,8'h00,8'h10,8'h00,1'b0,1'b0,1'b1, 8'hEF,8'h10,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFF,8'h00,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b1,1'b0,1'b1, 8'h00,8'hFF,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFF,8'h00,8'h00},
    {8'h0F,8'h00,8'h00,8'hF3,1'b0,1'b0,1'b1, 8'h0F,8'hF0,8'h00},
    {8'h0F,8'hF0,8'h00,8'h00,1'b0,1'b0,1'b1, 8'h0F,8'h00,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hFF,8'h00,8'h00},
    {8'hFF,8'h01,8'h01,8'h00,1'b0,1'b1,1'b1, 8'hFE,8'h01,8'h00},
    {8'hFF,8'h02,8'h00,8'h00,1'b1,1'b1,1'b1, 8'h00,8'hFF,8'h00},
    {8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00},
    {8'hFF,8'h08,8'h00,8'h00,1'b0,1'b0,1'b1, 8'hF7,8'h08,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b1,1'b1, 8'hF7,8'h08,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b1,1'b0, 8'hF7,8'h08,8'h00},
    {8'hFF,8'h00,8'h00,8'h00,1'b0,1'b1,1'b1, 8'hFF,8'h00,8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cmd_on = '0, short_s = '0, hot_s = '0, open_s = '0;
  logic ovolt = 1'b0, mode = 1'b0, cs_n = 1'b1;
  logic [N-1:0] gate_en, limit, fault;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  chan_guard #(.NUM_CH(N)) u_chan_guard (
    .clk_i(clk), .rst_ni(rst_n), .cmd_on_i(cmd_on), .short_i(short_s),
    .hot_i(hot_s), .open_i(open_s), .ovolt_i(ovolt), .limit_mode_i(mode),
    .cs_n_i(cs_n), .gate_en_o(gate_en), .limit_o(limit), .fault_o(fault)
  );

  function automatic string row_req(int i);
    if (i <= 2) return "R1";
    if (i <= 10) return "R3";
    if (i <= 12) return "R2";
    if (i <= 14) return "R4";
    if (i <= 16) return "R5";
    if (i == 17) return "R6";
    if (i <= 19) return "R8";
    if (i <= 21) return "R2";
    if (i == 22) return "R10";
    return "R9";
  endfunction

  task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [58:0] v);
    cmd_on  = v[58:51];
    short_s = v[50:43];
    hot_s   = v[42:35];
    open_s  = v[34:27];
    ovolt   = v[26];
    mode    = v[25];
    cs_n    = v[24];
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R7: state held in reset
    repeat (2) @(negedge clk);
    check("R7", "gate in reset", gate_en, '0);
    check("R7", "fault in reset", fault, '0);
    rst_n = 1'b1;

    // R10: each row checked exactly one edge after it is driven
    for (int i = 0; i < ROWS; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check(row_req(i), $sformatf("row %0d gate", i), gate_en, TBL[i][23:16]);
      check(row_req(i), $sformatf("row %0d fault", i), fault, TBL[i][15:8]);
      check(row_req(i), $sformatf("row %0d limit", i), limit, TBL[i][7:0]);
    end

    // R7: asynchronous reset with a latched short
    drive({8'hFF,8'h02,8'h00,8'h00,1'b0,1'b0,1'b1, 24'h0});
    @(negedge clk);
    check("R1", "latched before reset", gate_en, 8'hFD);
    rst_n = 1'b0;
    #0.5;
    check("R7", "gate async clear", gate_en, '0);
    check("R7", "fault async clear", fault, '0);
    check("R7", "limit async clear", limit, '0);
    short_s = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "latch cleared by reset", gate_en, 8'hFF);
    check("R7", "fault after reset", fault, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule